// File: doc/BRIEF.md
# Return Stack with Object Context Register

This block is the return stack of a small stack processor whose memory is addressed by an object identifier and a field offset. Each stack entry is 32 bits wide. The low half holds a return address or a word pushed by the program. The high half is filled automatically with the object context that was current when the entry went on the stack. A context register holds the object identifier currently in use. Only two events change it. A return pops an entry and restores the context from that entry's high half. A send loads the context from the top of the data stack. Software that needs an arbitrary context overwrites the high half of the top entry and then returns.

The block also chooses the object identifier that goes with each memory access. The choice depends on a two-bit access code. Plain data accesses use the context. Auto-incrementing transfers through the return stack use the high half of the stack top. Instruction fetches use a masked copy of the context.

An occupancy state machine has three states: `ST_EMPTY`, `ST_PARTIAL` and `ST_FULL`. Its transitions are:
- fill: `ST_EMPTY` to `ST_PARTIAL` on a push.
- grow-to-full: `ST_PARTIAL` to `ST_FULL` when a push brings the depth to `DEPTH`.
- drain: `ST_FULL` to `ST_PARTIAL` on a pop.
- drain-to-empty: `ST_PARTIAL` to `ST_EMPTY` when the last entry is popped.
- hold: stay in the current state on a replace, an overflowing push, an underflowing pop, a high-half write or an idle cycle.

Top module: `rstk_ctx_unit`

## Requirements
- R1: A push (push_i=1, pop_i=0) with fewer than 16 entries stores {ctx_o, pushv_i} as the new top entry. The entry is visible on top_o after the clock edge.
- R2: A pop (pop_i=1, push_i=0) on a non-empty stack removes the top entry. The context becomes bits 31:16 of the removed entry, and the entry below becomes the top.
- R3: A send (send_i=1) loads ctx_o from dstk_i at the clock edge. It overrides a context restore from a pop in the same cycle. A push in the same cycle captures the context from before the send.
- R4: The context is unchanged after any cycle with neither a send nor a pop on a non-empty stack. This covers pushes, high-half writes and idle cycles.
- R5: hiwr_i with push_i=0 and pop_i=0 on a non-empty stack replaces bits 31:16 of the top entry with dstk_i and keeps bits 15:0. The write is ignored when the stack is empty or when push_i or pop_i is set.
- R6: A push and a pop in the same cycle on a non-empty stack replace the top entry with {ctx_o, pushv_i}. The depth is unchanged, and the context is restored from bits 31:16 of the replaced entry.
- R7: A push alone on a stack with 16 entries drops the value, leaves the stack unchanged and sets ovf_o. ovf_o stays set until reset.
- R8: A pop alone on an empty stack sets unf_o, which stays set until reset, and leaves the context unchanged. top_o is zero whenever the stack is empty. A push and a pop together on an empty stack perform the push and set unf_o.
- R9: Access codes 2'b00 (data) and 2'b11 (alternate data) give objid_o = ctx_o.
- R10: Access code 2'b01 (return-stack transfer) gives objid_o = top_o[31:16].
- R11: Access code 2'b10 (instruction fetch) gives objid_o = 0 when ctx_o[15] is 0. When ctx_o[15] is 1, objid_o is ctx_o with 0, 4, 8 or 12 low bits cleared, for ctx_o[14:13] equal to 00, 01, 10 or 11 respectively.
- R12: After reset the stack is empty, top_o is 0, ctx_o is 0, and ovf_o and unf_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push strobe (call or push of a word) |
| pop_i | input | 1 | Pop strobe (return) |
| send_i | input | 1 | Send strobe: load the context from dstk_i |
| hiwr_i | input | 1 | Overwrite the high half of the top entry with dstk_i |
| pushv_i | input | 16 | Word pushed into the low half of an entry |
| dstk_i | input | 16 | Top of the data stack |
| acc_i | input | 2 | Access code that selects the object identifier |
| top_o | output | 32 | Top entry (zero when empty) |
| ctx_o | output | 16 | Current context register |
| objid_o | output | 16 | Object identifier for the current access |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
Stack contents, context and flags are registered. Each of them is due one clock edge after the strobes that cause it. The bench drives strobes on a falling edge, lets one rising edge pass, and compares top_o, ctx_o, ovf_o and unf_o against its own model at the next falling edge. objid_o is combinational in acc_i and the registered state, so it is due in the same cycle the code is applied. The bench compares it a short delay after changing acc_i, with no clock edge in between.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    // Occupancy of the return stack
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_e;

    // Operation issued to the entry storage in a cycle
    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_REPL = 3'd3,
        OP_HIWR = 3'd4
    } stk_op_e;

    // Access code that picks the object identifier source
    typedef enum logic [1:0] {
        ACC_DATA  = 2'b00,
        ACC_RSTK  = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_ALT   = 2'b11
    } acc_e;

    // Number of low bits cleared per step of the fetch mask class
    localparam int unsigned MASK_STEP = 4;

    // Masked context used for instruction fetch
    function automatic logic [15:0] fetch_obj(input logic [15:0] ctx);
        logic [15:0] keep;
        keep = 16'hFFFF << (MASK_STEP * int'(ctx[14:13]));
        if (!ctx[15]) begin
            return 16'h0000;
        end
        return ctx & keep;
    endfunction

endpackage

// File: rtl/rstk_store.sv
module rstk_store
    import rstk_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned HW    = 16,
    parameter int unsigned PW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  stk_op_e         op_i,
    input  logic [PW-1:0]   sp_i,
    input  logic [HW-1:0]   lo_i,
    input  logic [HW-1:0]   hi_i,
    output logic [2*HW-1:0] top_o
);

    localparam int unsigned EW = 2 * HW;

    logic [EW-1:0] ent_q [DEPTH];
    logic [PW-1:0] tgt;
    logic          full_wr;
    logic          half_wr;

    // Push writes above the top; replace and high-half writes hit the top
    always_comb begin
        full_wr = (op_i == OP_PUSH) || (op_i == OP_REPL);
        half_wr = (op_i == OP_HIWR);
        if (op_i == OP_PUSH) begin
            tgt = sp_i;
        end else begin
            tgt = sp_i - PW'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else if (full_wr && (tgt == PW'(g))) begin
                ent_q[g] <= {hi_i, lo_i};
            end else if (half_wr && (tgt == PW'(g))) begin
                ent_q[g][EW-1:HW] <= hi_i;
            end
        end
    end

    // Top entry read by depth match, zero when empty
    always_comb begin
        top_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sp_i == PW'(i + 1)) begin
                top_o = ent_q[i];
            end
        end
    end

endmodule

// File: rtl/rstk_ctx_reg.sv
module rstk_ctx_reg #(
    parameter int unsigned HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          send_ld_i,
    input  logic [HW-1:0] send_val_i,
    input  logic          ret_ld_i,
    input  logic [HW-1:0] ret_val_i,
    output logic [HW-1:0] ctx_o
);

    logic [HW-1:0] ctx_q;

    // Send has priority over the restore from a return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else if (send_ld_i) begin
            ctx_q <= send_val_i;
        end else if (ret_ld_i) begin
            ctx_q <= ret_val_i;
        end
    end

    assign ctx_o = ctx_q;

endmodule

// File: rtl/rstk_objsel.sv
module rstk_objsel
    import rstk_pkg::*;
#(
    parameter int unsigned HW = 16
) (
    input  logic [1:0]    acc_i,
    input  logic [HW-1:0] ctx_i,
    input  logic [HW-1:0] rtop_hi_i,
    output logic [HW-1:0] objid_o
);

    acc_e acc;

    always_comb begin
        acc = acc_e'(acc_i);
        unique case (acc)
            ACC_RSTK:  objid_o = rtop_hi_i;
            ACC_FETCH: objid_o = HW'(fetch_obj(16'(ctx_i)));
            ACC_DATA,
            ACC_ALT:   objid_o = ctx_i;
            default:   objid_o = ctx_i;
        endcase
    end

endmodule

// File: rtl/rstk_ctx_unit.sv
module rstk_ctx_unit
    import rstk_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned HW    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic            send_i,
    input  logic            hiwr_i,
    input  logic [HW-1:0]   pushv_i,
    input  logic [HW-1:0]   dstk_i,
    input  logic [1:0]      acc_i,
    output logic [2*HW-1:0] top_o,
    output logic [HW-1:0]   ctx_o,
    output logic [HW-1:0]   objid_o,
    output logic            ovf_o,
    output logic            unf_o
);

    localparam int unsigned PW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] SP_MAX = PW'(DEPTH);
    localparam logic [PW-1:0] SP_ONE = PW'(1);

    occ_e          state_q, state_d;
    logic [PW-1:0] sp_q, sp_d;
    logic          ovf_q, ovf_d;
    logic          unf_q, unf_d;
    stk_op_e       op;
    logic          ret_ld;
    logic [HW-1:0] wr_hi;
    logic          do_push, do_pop, do_both;

    assign do_push = push_i && !pop_i;
    assign do_pop  = pop_i && !push_i;
    assign do_both = push_i && pop_i;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            sp_q    <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sp_q    <= sp_d;
            ovf_q   <= ovf_d;
            unf_q   <= unf_d;
        end
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        sp_d    = sp_q;
        ovf_d   = ovf_q;
        unf_d   = unf_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (push_i) begin
                    sp_d    = SP_ONE;
                    state_d = (SP_ONE == SP_MAX) ? ST_FULL : ST_PARTIAL;
                end
                if (pop_i) begin
                    unf_d = 1'b1;
                end
            end
            ST_PARTIAL: begin
                if (do_push) begin
                    sp_d    = sp_q + SP_ONE;
                    state_d = (sp_q + SP_ONE == SP_MAX) ? ST_FULL : ST_PARTIAL;
                end else if (do_pop) begin
                    sp_d    = sp_q - SP_ONE;
                    state_d = (sp_q == SP_ONE) ? ST_EMPTY : ST_PARTIAL;
                end
            end
            ST_FULL: begin
                if (do_push) begin
                    ovf_d = 1'b1;
                end else if (do_pop) begin
                    sp_d    = sp_q - SP_ONE;
                    state_d = (sp_q == SP_ONE) ? ST_EMPTY : ST_PARTIAL;
                end
            end
            default: begin
                state_d = ST_EMPTY;
                sp_d    = '0;
            end
        endcase
    end

    // Output process: storage operation and context restore
    always_comb begin
        op     = OP_IDLE;
        ret_ld = 1'b0;
        wr_hi  = ctx_o;
        unique case (state_q)
            ST_EMPTY: begin
                if (push_i) begin
                    op = OP_PUSH;
                end
            end
            ST_PARTIAL: begin
                if (do_both) begin
                    op     = OP_REPL;
                    ret_ld = 1'b1;
                end else if (do_push) begin
                    op = OP_PUSH;
                end else if (do_pop) begin
                    op     = OP_POP;
                    ret_ld = 1'b1;
                end else if (hiwr_i) begin
                    op    = OP_HIWR;
                    wr_hi = dstk_i;
                end
            end
            ST_FULL: begin
                if (do_both) begin
                    op     = OP_REPL;
                    ret_ld = 1'b1;
                end else if (do_pop) begin
                    op     = OP_POP;
                    ret_ld = 1'b1;
                end else if (hiwr_i && !push_i) begin
                    op    = OP_HIWR;
                    wr_hi = dstk_i;
                end
            end
            default: begin
                op = OP_IDLE;
            end
        endcase
    end

    rstk_store #(
        .DEPTH (DEPTH),
        .HW    (HW),
        .PW    (PW)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (op),
        .sp_i  (sp_q),
        .lo_i  (pushv_i),
        .hi_i  (wr_hi),
        .top_o (top_o)
    );

    rstk_ctx_reg #(
        .HW (HW)
    ) u_ctx (
        .clk        (clk),
        .rst_n      (rst_n),
        .send_ld_i  (send_i),
        .send_val_i (dstk_i),
        .ret_ld_i   (ret_ld),
        .ret_val_i  (top_o[2*HW-1:HW]),
        .ctx_o      (ctx_o)
    );

    rstk_objsel #(
        .HW (HW)
    ) u_sel (
        .acc_i     (acc_i),
        .ctx_i     (ctx_o),
        .rtop_hi_i (top_o[2*HW-1:HW]),
        .objid_o   (objid_o)
    );

    assign ovf_o = ovf_q;
    assign unf_o = unf_q;

endmodule

// File: rtl/rstk_ctx_chk.sv
module rstk_ctx_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned HW    = 16,
    parameter int unsigned PW    = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            push_i,
    input logic            pop_i,
    input logic            send_i,
    input logic [HW-1:0]   pushv_i,
    input logic [HW-1:0]   dstk_i,
    input logic [1:0]      acc_i,
    input logic [2*HW-1:0] top_o,
    input logic [HW-1:0]   ctx_o,
    input logic [HW-1:0]   objid_o,
    input logic            ovf_o,
    input logic            unf_o,
    input logic [PW-1:0]   sp_q
);

    // R1
    push_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && (sp_q != PW'(DEPTH)))
        |=> (top_o == {$past(ctx_o), $past(pushv_i)}));

    // R2
    ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !send_i && (sp_q != '0))
        |=> (ctx_o == $past(top_o[2*HW-1:HW])));

    // R3
    send_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_i |=> (ctx_o == $past(dstk_i)));

    // R4
    ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!send_i && !(pop_i && (sp_q != '0))) |=> $stable(ctx_o));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    // R8
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> unf_o);

    // R8
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_q == '0) |-> (top_o == '0));

    // R10
    rstk_obj_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i == 2'b01) |-> (objid_o == top_o[2*HW-1:HW]));

    // R11
    fetch_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_i == 2'b10) && !ctx_o[HW-1]) |-> (objid_o == '0));

endmodule

bind rstk_ctx_unit rstk_ctx_chk #(
    .DEPTH (DEPTH),
    .HW    (HW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .send_i  (send_i),
    .pushv_i (pushv_i),
    .dstk_i  (dstk_i),
    .acc_i   (acc_i),
    .top_o   (top_o),
    .ctx_o   (ctx_o),
    .objid_o (objid_o),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o),
    .sp_q    (sp_q)
);

// File: tb/rstk_ctx_unit_tb.sv
module rstk_ctx_unit_tb;

    logic        clk;
    logic        rst_n;
    logic        push_i, pop_i, send_i, hiwr_i;
    logic [15:0] pushv_i, dstk_i;
    logic [1:0]  acc_i;
    logic [31:0] top_o;
    logic [15:0] ctx_o, objid_o;
    logic        ovf_o, unf_o;

    int checks = 0;
    int errors = 0;

    // Reference model
    logic [31:0] mdl [16];
    int          msp;
    logic [15:0] mctx;
    logic        movf, munf;

    rstk_ctx_unit u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .send_i  (send_i),
        .hiwr_i  (hiwr_i),
        .pushv_i (pushv_i),
        .dstk_i  (dstk_i),
        .acc_i   (acc_i),
        .top_o   (top_o),
        .ctx_o   (ctx_o),
        .objid_o (objid_o),
        .ovf_o   (ovf_o),
        .unf_o   (unf_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mtop();
        if (msp == 0) return 32'h0;
        return mdl[msp-1];
    endfunction

    function automatic logic [15:0] exp_obj(input logic [1:0] a);
        logic [15:0] clr;
        case (a)
            2'b01: return mtop()>>16;
            2'b10: begin
                if (mctx[15] == 1'b0) return 16'h0;
                clr = 16'((32'h1 << (4 * int'(mctx[14:13]))) - 1);
                return mctx & ~clr;
            end
            default: return mctx;
        endcase
    endfunction

    task automatic compare_all(input string tag);
        chk({tag, " top"}, top_o, mtop());
        chk({tag, " ctx"}, {16'h0, ctx_o}, {16'h0, mctx});
        chk({tag, " ovf"}, {31'h0, ovf_o}, {31'h0, movf});
        chk({tag, " unf"}, {31'h0, unf_o}, {31'h0, munf});
    endtask

    task automatic obj_check(input string tag, input logic [1:0] a);
        acc_i = a;
        #2;
        chk(tag, {16'h0, objid_o}, {16'h0, exp_obj(a)});
    endtask

    // Drive one cycle of strobes; results are due after one rising edge
    task automatic step(input string tag, input bit pu, input bit po, input bit se,
                        input bit hw, input logic [15:0] pv, input logic [15:0] dv);
        logic [15:0] octx;
        logic [31:0] otop;
        push_i = pu; pop_i = po; send_i = se; hiwr_i = hw;
        pushv_i = pv; dstk_i = dv;
        @(posedge clk);
        octx = mctx;
        otop = mtop();
        if (pu && po) begin
            if (msp == 0) begin
                mdl[0] = {octx, pv}; msp = 1; munf = 1'b1;
            end else begin
                mdl[msp-1] = {octx, pv}; mctx = otop[31:16];
            end
        end else if (pu) begin
            if (msp == 16) movf = 1'b1;
            else begin mdl[msp] = {octx, pv}; msp++; end
        end else if (po) begin
            if (msp == 0) munf = 1'b1;
            else begin mctx = otop[31:16]; msp--; end
        end else if (hw && msp != 0) begin
            mdl[msp-1][31:16] = dv;
        end
        if (se) mctx = dv;
        @(negedge clk);
        push_i = 0; pop_i = 0; send_i = 0; hiwr_i = 0;
        compare_all(tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        push_i = 0; pop_i = 0; send_i = 0; hiwr_i = 0;
        pushv_i = 0; dstk_i = 0; acc_i = 0;
        msp = 0; mctx = 0; movf = 0; munf = 0;
        for (int i = 0; i < 16; i++) mdl[i] = 32'h0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R12 reset");

        // R9 R10 R11: sweep of context class bits with several low patterns
        for (int c = 0; c < 8; c++) begin
            for (int l = 0; l < 3; l++) begin
                logic [12:0] low;
                low = (l == 0) ? 13'h1FFF : (l == 1) ? 13'h0A5C : 13'h0000;
                step("R3 send sweep", 0, 0, 1, 0, 16'h0, {3'(c), low});
                obj_check("R11 fetch objid", 2'b10);
                obj_check("R9 data objid", 2'b00);
                obj_check("R9 alt objid", 2'b11);
                obj_check("R10 rstk objid empty", 2'b01);
            end
        end

        // R1 R4: fill the stack, changing context every fourth push
        for (int i = 0; i < 16; i++) begin
            if (i % 4 == 0) step("R3 send", 0, 0, 1, 0, 16'h0, 16'hA000 + 16'(i * 257));
            step("R1 R4 push", 1, 0, 0, 0, 16'h1000 + 16'(i), 16'h0);
            obj_check("R10 rstk objid", 2'b01);
        end

        // R7: overflow drops value
        step("R7 overflow", 1, 0, 0, 0, 16'hDEAD, 16'h0);
        step("R7 overflow sticky", 1, 0, 0, 0, 16'hBEEF, 16'h0);
        step("R7 idle", 0, 0, 0, 0, 16'h0, 16'h0);

        // R6: replace at full
        step("R6 replace full", 1, 1, 0, 0, 16'h7777, 16'h0);
        // R5: high-half write ignored when push active
        step("R5 hiwr with push", 1, 0, 0, 1, 16'h5555, 16'h4321);

        // R2: pop everything back out
        for (int i = 0; i < 16; i++) begin
            step("R2 pop", 0, 1, 0, 0, 16'h0, 16'h0);
            obj_check("R10 rstk objid pop", 2'b01);
        end

        // R8: underflow behaviour
        step("R8 pop empty", 0, 1, 0, 0, 16'h0, 16'h0);
        obj_check("R10 empty objid", 2'b01);
        step("R5 hiwr empty", 0, 0, 0, 1, 16'h0, 16'h9999);
        step("R8 push pop empty", 1, 1, 0, 0, 16'h0042, 16'h0);

        // R5 R4: set context through high-half write then return
        step("R1 push", 1, 0, 0, 0, 16'h0123, 16'h0);
        step("R5 R4 hiwr", 0, 0, 0, 1, 16'h0, 16'hC123);
        step("R5 hiwr with pop", 0, 1, 0, 1, 16'h0, 16'h1111);
        step("R2 return sets ctx", 0, 1, 0, 0, 16'h0, 16'h0);

        // R3: send with push and with pop in the same cycle
        step("R1 push", 1, 0, 0, 0, 16'h0AAA, 16'h0);
        step("R3 send with push", 1, 0, 1, 0, 16'h0BBB, 16'h8E00);
        step("R3 send with pop", 0, 1, 1, 0, 16'h0, 16'hE5F0);
        step("R6 replace", 1, 1, 0, 0, 16'h0CCC, 16'h0);
        obj_check("R11 fetch final", 2'b10);
        step("R2 pop final", 0, 1, 0, 0, 16'h0, 16'h0);

        finish_run();
    end

endmodule